// File: doc/BRIEF.md
# Self-programming flash command controller

This block sequences the commands a small processor uses to rewrite its own program memory. Software first writes a five-bit command into a control register. It then issues a store strobe that carries a byte address and a 16-bit data word. Between those two steps the command stays armed for four clocks only. If no strobe comes in that time, the command clears itself.

The block owns a page buffer of sixteen-bit words. A plain store puts one word into this buffer. Other commands can wipe the whole buffer to all ones, erase one page of the array, or program the buffer contents into one page of the array. A lock-bit command is passed on to the array as a one-cycle pulse. While an erase or a program runs, the block holds the processor halted and keeps the command bits visible. It releases both when the array signals done.

Top module: `spm_ctrl`

## Requirements
- R1: After reset the command read-back is zero, the halt output is low, both array requests are low, the lock pulse is low and every buffer word reads 16'hFFFF.
- R2: Register bits [4:0] are, high to low: wipe, lock, program, erase, enable. Only the patterns 5'b10001, 5'b01001, 5'b00101, 5'b00011 and 5'b00001 are accepted. Any other pattern leaves the command bits unchanged.
- R3: A command written at edge E0 accepts a strobe sampled at edges E1 to E4. If no strobe arrives by E4, the command bits read zero after E4. A strobe at E5 or later has no effect.
- R4: With 5'b00001 armed, a strobe writes the data word into buffer word Z[5:1]. Z bit 0 is ignored. The command bits then read zero.
- R5: With 5'b00011 armed, a strobe raises the erase request with page Z[15:6] and leaves the buffer unchanged. Erase and program requests are never high together.
- R6: With 5'b00101 armed, a strobe raises the program request with page Z[15:6]. The buffer contents stay readable on the array read port during the operation.
- R7: The halt output rises in the cycle after an erase or program strobe and stays high until the cycle after done.
- R8: During an erase or program, the command bits hold their value until done. After done they read zero and the request drops.
- R9: With 5'b10001 armed, a strobe sets every buffer word to 16'hFFFF in one cycle.
- R10: With 5'b01001 armed, a strobe produces a one-cycle lock pulse that carries data bits [7:0]. The command bits then read zero.
- R11: Register writes made while an erase or program is busy are ignored.
- R12: The register read-back shows the live command bits in [4:0] and zero above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Live control register read-back |
| spm_stb | input | 1 | Store strobe from the processor |
| spm_z | input | 16 | Byte address of the store |
| spm_data | input | 16 | Data word of the store |
| arr_erase_req | output | 1 | Page erase request to the array |
| arr_write_req | output | 1 | Page program request to the array |
| arr_page | output | 10 | Page number for erase or program |
| arr_done | input | 1 | Array reports completion |
| arr_buf_idx | input | 5 | Buffer word index read by the array |
| arr_buf_data | output | 16 | Buffer word at arr_buf_idx |
| lock_req | output | 1 | One-cycle lock-bit request |
| lock_data | output | 8 | Lock-bit value for the request |
| cpu_halt | output | 1 | Processor stall |

## Verification
The assertions check five properties on every cycle. The held command is always zero or one of the five legal patterns. The two array requests never overlap. The command bits and the halt stay frozen while an operation waits for done. The lock pulse lasts one cycle, and a wipe leaves every word all ones. Only the bench scenarios show the rest: the exact edges that bound the arming window, which buffer word a store reaches and that Z bit 0 does not matter, the page number taken from the address, and that writes during a busy operation are discarded.

// File: rtl/spm_pkg.sv
package spm_pkg;
   localparam int CMD_W = 5;
   typedef logic [CMD_W-1:0] cmd_t;

   localparam cmd_t CMD_STORE = 5'b00001;
   localparam cmd_t CMD_ERASE = 5'b00011;
   localparam cmd_t CMD_PROG  = 5'b00101;
   localparam cmd_t CMD_LOCK  = 5'b01001;
   localparam cmd_t CMD_WIPE  = 5'b10001;

   typedef enum logic [2:0] {
      OP_NONE, OP_STORE, OP_ERASE, OP_PROG, OP_LOCK, OP_WIPE
   } op_e;

   function automatic logic cmd_legal(cmd_t c);
      return (c == CMD_STORE) || (c == CMD_ERASE) || (c == CMD_PROG) ||
             (c == CMD_LOCK)  || (c == CMD_WIPE);
   endfunction
endpackage

// File: rtl/spm_cmd_decode.sv
module spm_cmd_decode
   import spm_pkg::*;
(
   input  cmd_t held,
   input  cmd_t cand,
   output op_e  op,
   output logic cand_ok
);
   always_comb begin
      unique case (held)
         CMD_STORE: op = OP_STORE;
         CMD_ERASE: op = OP_ERASE;
         CMD_PROG:  op = OP_PROG;
         CMD_LOCK:  op = OP_LOCK;
         CMD_WIPE:  op = OP_WIPE;
         default:   op = OP_NONE;
      endcase
   end

   assign cand_ok = cmd_legal(cand);
endmodule

// File: rtl/spm_arm_timer.sv
module spm_arm_timer #(
   parameter int WINDOW = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic take,
   input  logic hold,
   output logic live,
   output logic expire
);
   localparam int CW = $clog2(WINDOW + 1);

   logic [CW-1:0] cnt_q;

   initial begin
      assert (WINDOW >= 1) else $fatal(1, "WINDOW must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= '0;
      else if (load)     cnt_q <= CW'(WINDOW);
      else if (hold)     cnt_q <= cnt_q;
      else if (take)     cnt_q <= '0;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign live   = (cnt_q != '0);
   assign expire = (cnt_q == CW'(1)) && !take && !hold && !load;

   p_window_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(WINDOW));
endmodule

// File: rtl/spm_page_buf.sv
module spm_page_buf #(
   parameter int WORDS  = 32,
   parameter int WORD_W = 16,
   parameter bit RD_REG = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [$clog2(WORDS)-1:0]   wr_idx,
   input  logic [WORD_W-1:0]          wr_data,
   input  logic                       wipe,
   input  logic [$clog2(WORDS)-1:0]   rd_idx,
   output logic [WORD_W-1:0]          rd_data
);
   localparam int IDX_W = $clog2(WORDS);

   logic [WORD_W-1:0] word_q [WORDS];

   initial begin
      assert (WORDS >= 2 && (1 << IDX_W) == WORDS)
         else $fatal(1, "WORDS must be a power of two");
   end

   for (genvar g = 0; g < WORDS; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n || wipe)
            word_q[g] <= '1;
         else if (wr_en && wr_idx == IDX_W'(g))
            word_q[g] <= wr_data;
      end

      p_wipe_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
         wipe |=> (word_q[g] == '1));
   end

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) rd_data <= '1;
         else        rd_data <= word_q[rd_idx];
      end
   end else begin : g_rd_comb
      assign rd_data = word_q[rd_idx];
   end
endmodule

// File: rtl/spm_ctrl.sv
module spm_ctrl
   import spm_pkg::*;
#(
   parameter int REG_W  = 8,
   parameter int Z_W    = 16,
   parameter int WORD_W = 16,
   parameter int WORDS  = 32,
   parameter int WINDOW = 4,
   parameter int LOCK_W = 8,
   localparam int IDX_W  = $clog2(WORDS),
   localparam int PAGE_W = Z_W - IDX_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              spm_stb,
   input  logic [Z_W-1:0]    spm_z,
   input  logic [WORD_W-1:0] spm_data,
   output logic              arr_erase_req,
   output logic              arr_write_req,
   output logic [PAGE_W-1:0] arr_page,
   input  logic              arr_done,
   input  logic [IDX_W-1:0]  arr_buf_idx,
   output logic [WORD_W-1:0] arr_buf_data,
   output logic              lock_req,
   output logic [LOCK_W-1:0] lock_data,
   output logic              cpu_halt
);
   initial begin
      assert (REG_W >= CMD_W) else $fatal(1, "REG_W too small");
      assert (PAGE_W >= 1) else $fatal(1, "Z_W too small for WORDS");
      assert (LOCK_W <= WORD_W) else $fatal(1, "LOCK_W too wide");
   end

   cmd_t              bits_q;
   logic              busy_q, erase_q, prog_q, lock_q;
   logic [PAGE_W-1:0] page_q;
   logic [LOCK_W-1:0] lock_data_q;

   op_e  op;
   logic cand_ok, live, expire, take, wr_ok;
   logic unused_bits;

   spm_cmd_decode u_dec (
      .held    (bits_q),
      .cand    (reg_wdata[CMD_W-1:0]),
      .op      (op),
      .cand_ok (cand_ok)
   );

   assign take  = spm_stb && bits_q[0] && live && !busy_q;
   assign wr_ok = reg_wr && !busy_q && !take && cand_ok;

   spm_arm_timer #(.WINDOW(WINDOW)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (wr_ok),
      .take   (take),
      .hold   (busy_q),
      .live   (live),
      .expire (expire)
   );

   spm_page_buf #(.WORDS(WORDS), .WORD_W(WORD_W), .RD_REG(1'b0)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (take && op == OP_STORE),
      .wr_idx  (spm_z[IDX_W:1]),
      .wr_data (spm_data),
      .wipe    (take && op == OP_WIPE),
      .rd_idx  (arr_buf_idx),
      .rd_data (arr_buf_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bits_q      <= '0;
         busy_q      <= 1'b0;
         erase_q     <= 1'b0;
         prog_q      <= 1'b0;
         lock_q      <= 1'b0;
         page_q      <= '0;
         lock_data_q <= '0;
      end else begin
         lock_q <= 1'b0;
         if (busy_q) begin
            if (arr_done) begin
               busy_q  <= 1'b0;
               erase_q <= 1'b0;
               prog_q  <= 1'b0;
               bits_q  <= '0;
            end
         end else if (take) begin
            unique case (op)
               OP_ERASE: begin
                  busy_q  <= 1'b1;
                  erase_q <= 1'b1;
                  page_q  <= spm_z[Z_W-1:IDX_W+1];
               end
               OP_PROG: begin
                  busy_q <= 1'b1;
                  prog_q <= 1'b1;
                  page_q <= spm_z[Z_W-1:IDX_W+1];
               end
               OP_LOCK: begin
                  lock_q      <= 1'b1;
                  lock_data_q <= spm_data[LOCK_W-1:0];
                  bits_q      <= '0;
               end
               default: bits_q <= '0;
            endcase
         end else if (wr_ok) begin
            bits_q <= reg_wdata[CMD_W-1:0];
         end else if (expire) begin
            bits_q <= '0;
         end
      end
   end

   assign reg_rdata     = {{(REG_W-CMD_W){1'b0}}, bits_q};
   assign arr_erase_req = erase_q;
   assign arr_write_req = prog_q;
   assign arr_page      = page_q;
   assign lock_req      = lock_q;
   assign lock_data     = lock_data_q;
   assign cpu_halt      = busy_q;
   assign unused_bits   = ^{spm_z[0], reg_wdata[REG_W-1:CMD_W]};

   p_legal_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bits_q == '0) || cmd_legal(bits_q));

   p_armed_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bits_q[0] && !busy_q) |-> live);

   p_single_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(arr_erase_req && arr_write_req));

   p_halt_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (op == OP_ERASE || op == OP_PROG)) |=> cpu_halt);

   p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_halt && !arr_done) |=> cpu_halt);

   p_hold_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_halt && !arr_done) |=> $stable(reg_rdata));

   p_lock_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lock_req |=> !lock_req);
endmodule

// File: tb/sim_spm_ctrl.sv
module sim_spm_ctrl;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        spm_stb = 1'b0;
   logic [15:0] spm_z = '0;
   logic [15:0] spm_data = '0;
   logic        arr_erase_req, arr_write_req;
   logic [9:0]  arr_page;
   logic        arr_done = 1'b0;
   logic [4:0]  arr_buf_idx = '0;
   logic [15:0] arr_buf_data;
   logic        lock_req;
   logic [7:0]  lock_data;
   logic        cpu_halt;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spm_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .spm_stb(spm_stb), .spm_z(spm_z),
      .spm_data(spm_data), .arr_erase_req(arr_erase_req),
      .arr_write_req(arr_write_req), .arr_page(arr_page),
      .arr_done(arr_done), .arr_buf_idx(arr_buf_idx),
      .arr_buf_data(arr_buf_data), .lock_req(lock_req),
      .lock_data(lock_data), .cpu_halt(cpu_halt)
   );

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic buf_word(input string req, input int idx,
                           input logic [15:0] exp);
      arr_buf_idx = 5'(idx);
      #1;
      check(req, {16'h0, arr_buf_data}, {16'h0, exp});
   endtask

   task automatic reg_write(input logic [7:0] v);
      reg_wr = 1'b1;
      reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic strobe(input logic [15:0] z, input logic [15:0] d);
      spm_stb = 1'b1;
      spm_z = z;
      spm_data = d;
      @(negedge clk);
      spm_stb = 1'b0;
   endtask

   task automatic t_reset;
      check("R1 rdata", {24'h0, reg_rdata}, 32'h0);
      check("R1 halt", {31'h0, cpu_halt}, 32'h0);
      check("R1 reqs", {30'h0, arr_erase_req, arr_write_req}, 32'h0);
      check("R1 lock", {31'h0, lock_req}, 32'h0);
      buf_word("R1 buffer", 9, 16'hFFFF);
   endtask

   task automatic t_store;
      reg_write(8'h01);
      strobe(16'h0004, 16'h1234);
      buf_word("R4 word2", 2, 16'h1234);
      check("R4 bits cleared", {24'h0, reg_rdata}, 32'h0);
      reg_write(8'h01);
      strobe(16'h0007, 16'hABCD);
      buf_word("R4 z bit0 ignored", 3, 16'hABCD);
   endtask

   task automatic t_window;
      reg_write(8'hE1);
      repeat (3) @(negedge clk);
      check("R12 live readback", {24'h0, reg_rdata}, 32'h01);
      @(negedge clk);
      check("R3 expired after E4", {24'h0, reg_rdata}, 32'h0);
      reg_write(8'h01);
      repeat (3) @(negedge clk);
      strobe(16'h000A, 16'h5555);
      buf_word("R3 strobe at E4", 5, 16'h5555);
      reg_write(8'h01);
      repeat (4) @(negedge clk);
      strobe(16'h000C, 16'h6666);
      buf_word("R3 strobe at E5 ignored", 6, 16'hFFFF);
   endtask

   task automatic t_illegal;
      reg_write(8'h07);
      check("R2 illegal from idle", {24'h0, reg_rdata}, 32'h0);
      reg_write(8'h01);
      reg_write(8'h19);
      check("R2 illegal keeps armed", {24'h0, reg_rdata}, 32'h01);
      repeat (4) @(negedge clk);
   endtask

   task automatic t_erase;
      reg_write(8'h03);
      strobe(16'h0FC0, 16'h0BAD);
      check("R5 erase req", {30'h0, arr_erase_req, arr_write_req}, 32'h2);
      check("R5 page", {22'h0, arr_page}, 32'h3F);
      check("R7 halt", {31'h0, cpu_halt}, 32'h1);
      buf_word("R5 buffer unchanged", 0, 16'hFFFF);
      repeat (5) @(negedge clk);
      check("R8 bits held", {24'h0, reg_rdata}, 32'h03);
      reg_write(8'h11);
      check("R11 write ignored", {24'h0, reg_rdata}, 32'h03);
      arr_done = 1'b1;
      @(negedge clk);
      arr_done = 1'b0;
      check("R8 cleared", {24'h0, reg_rdata}, 32'h0);
      check("R8 req dropped", {31'h0, arr_erase_req}, 32'h0);
      check("R7 halt released", {31'h0, cpu_halt}, 32'h0);
   endtask

   task automatic t_prog;
      reg_write(8'h05);
      strobe(16'h1240, 16'h0000);
      check("R6 write req", {30'h0, arr_erase_req, arr_write_req}, 32'h1);
      check("R6 page", {22'h0, arr_page}, 32'h49);
      check("R7 halt", {31'h0, cpu_halt}, 32'h1);
      buf_word("R6 buffer readable", 2, 16'h1234);
      arr_done = 1'b1;
      @(negedge clk);
      arr_done = 1'b0;
      check("R6 done", {24'h0, cpu_halt, arr_write_req, reg_rdata[5:0]}, 32'h0);
   endtask

   task automatic t_lock;
      reg_write(8'h09);
      strobe(16'h0000, 16'h77A5);
      check("R10 pulse", {31'h0, lock_req}, 32'h1);
      check("R10 data", {24'h0, lock_data}, 32'hA5);
      check("R10 bits cleared", {24'h0, reg_rdata}, 32'h0);
      @(negedge clk);
      check("R10 one cycle", {31'h0, lock_req}, 32'h0);
   endtask

   task automatic t_wipe;
      reg_write(8'h11);
      strobe(16'h0000, 16'h0000);
      for (int i = 0; i < 32; i++) buf_word("R9 wipe", i, 16'hFFFF);
      check("R9 bits cleared", {24'h0, reg_rdata}, 32'h0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_store();
            t_window();
            t_illegal();
            t_erase();
            t_prog();
            t_lock();
            t_wipe();
         end
         begin
            repeat (150000) @(negedge clk);
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule